// File: doc/BRIEF.md
# Stack Pointer Value Tracker

This block sits right after instruction decode and sees decoded micro-operations in program order, up to `LANES` per cycle. It keeps a private copy of the stack pointer. Simple updates of the form "stack pointer plus or minus an immediate" and "stack pointer gets an immediate" are applied to that copy as they pass. With this copy the block can give loads that address the stack an exact early effective address without predicting anything. Loads with an absolute address also get an early address.

When an update cannot be computed, the block moves to an unknown state. It records the sequence id of that micro-operation and then keeps a running delta of all later simple updates. When the execution core returns the result tagged with the recorded id, the block rebuilds the pointer as that result plus the delta.

Each branch saves the value or delta, the known flag and the recorded id into a checkpoint slot selected by the low bits of the branch's id. A misprediction flush restores that slot.

Top module: `stkptr_tracker`

## Requirements
- R1: After reset, `sp_known` is 1, `sp_value` equals `INIT_SP`, and `ea_vld` and `uop_untrk` are all 0.
- R2: A stack-based load produces no early address when the pointer is unknown at its slot. This includes the case where an earlier slot of the same cycle made it unknown.
- R3: A trackable update writes the pointer, with all arithmetic modulo 2^32. A trackable update has destination = stack pointer and an immediate second source. It is either ADD or SUB (op 1 or 2) with the stack pointer as first source, or MOVI (op 3), which needs no register source. ADD gives value+imm, SUB gives value−imm, and MOVI gives imm.
- R4: A load (op 4) with base = stack pointer (base code 1) and no index raises `ea_vld` for its lane one cycle later, with address = tracked value + displacement. `sp_value` is left unchanged.
- R5: A load whose base is another register (base code 2), or that has an index, gets no early address.
- R6: An update that writes the stack pointer but is not trackable makes the block unknown. It sets `sp_value` (now a delta) to 0 and records the micro-operation's id.
- R7: While unknown, ADD and SUB adjust the delta by the immediate. A further untrackable update resets the delta to 0 and replaces the recorded id. MOVI makes the pointer known with the immediate as its value.
- R8: A writeback whose id equals the recorded id while unknown makes the block known, with value = writeback value + delta. Micro-operations in the same cycle are applied after this rebuild.
- R9: `uop_untrk` for a lane is 1 one cycle after that lane carried an untrackable stack pointer update.
- R10: A branch (op 5) checkpoints the state before its slot into entry `id mod CKPT_DEPTH`. A flush restores that entry: a known entry is usable at once, and an unknown entry waits for its recorded id. Micro-operations presented in the flush cycle are discarded.
- R11: A load with no base (base code 0) and no index gets early address = displacement, in either state.
- R12: Lanes of one cycle are chained in order: each lane starts from the pointer left by the lanes before it.
- R13: A writeback whose id differs from the recorded id, or that arrives while known, changes nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| uop_vld | input | LANES | Lane carries a micro-operation |
| uop_op | input | 3*LANES | Operation: 0 other, 1 ADD, 2 SUB, 3 MOVI, 4 LOAD, 5 BRANCH |
| uop_dst_sp | input | LANES | Destination is the stack pointer |
| uop_src_sp | input | LANES | First source is the stack pointer |
| uop_src_imm | input | LANES | Second source is an immediate |
| uop_base | input | 2*LANES | Load base: 0 none, 1 stack pointer, 2 other register |
| uop_index | input | LANES | Load uses an index register |
| uop_imm | input | AW*LANES | Immediate or displacement |
| uop_id | input | IDW*LANES | Sequence id; low bits give the checkpoint slot of a branch |
| wb_vld | input | 1 | Execution result valid |
| wb_id | input | IDW | Id of the returned result |
| wb_val | input | AW | Returned stack pointer value |
| flush_vld | input | 1 | Misprediction flush |
| flush_tag | input | $clog2(CKPT_DEPTH) | Checkpoint slot to restore |
| ea_vld | output | LANES | Early address valid, one cycle after the load |
| ea_addr | output | AW*LANES | Early effective address |
| uop_untrk | output | LANES | Status bit: lane was an untrackable stack pointer update |
| sp_known | output | 1 | Tracked pointer is exact |
| sp_value | output | AW | Tracked value when known, delta when unknown |

## Verification
The bench targets slot ordering inside a cycle. It places a stack load after an update in the same cycle, and a stack load after an untrackable update in the same cycle. A design that reads the start-of-cycle value would give a stale address, or an address while unknown. It replays writebacks with a stale id and with an id that a later untrackable update has already replaced. It also sends a matching writeback together with a same-cycle update; a wrong design would lose the update or rebuild from the wrong delta. Flushes restore both a known slot and an unknown slot while a wrong-path update is presented. A design that kept the wrong-path work, or dropped the saved id, would end with the wrong value or never resynchronise. Modulo wrap is checked in both directions.

// File: rtl/sp_trk_pkg.sv
package sp_trk_pkg;
   typedef enum logic [2:0] {
      OP_OTHER  = 3'd0,
      OP_ADD    = 3'd1,
      OP_SUB    = 3'd2,
      OP_MOVI   = 3'd3,
      OP_LOAD   = 3'd4,
      OP_BRANCH = 3'd5
   } sp_op_e;

   typedef enum logic [1:0] {
      BASE_NONE = 2'd0,
      BASE_SP   = 2'd1,
      BASE_GPR  = 2'd2
   } sp_base_e;

   localparam int OPW = 3;
   localparam int BSW = 2;
endpackage

// File: rtl/sp_trk_step.sv
module sp_trk_step
   import sp_trk_pkg::*;
#(
   parameter int AW  = 32,
   parameter int IDW = 8
) (
   input  logic           vld,
   input  logic [OPW-1:0] op,
   input  logic           dst_sp,
   input  logic           src_sp,
   input  logic           src_imm,
   input  logic [BSW-1:0] base,
   input  logic           index,
   input  logic [AW-1:0]  imm,
   input  logic [IDW-1:0] id,
   input  logic           known_i,
   input  logic [AW-1:0]  val_i,
   input  logic [IDW-1:0] pid_i,
   output logic           known_o,
   output logic [AW-1:0]  val_o,
   output logic [IDW-1:0] pid_o,
   output logic           ea_vld,
   output logic [AW-1:0]  ea,
   output logic           untrk,
   output logic           is_branch
);
   logic trackable;
   logic is_load;

   always_comb begin
      trackable = dst_sp && src_imm &&
                  (((op == OP_ADD) || (op == OP_SUB)) && src_sp || (op == OP_MOVI));
      untrk     = vld && dst_sp && !trackable;
      is_branch = vld && (op == OP_BRANCH);
      is_load   = vld && (op == OP_LOAD) && !index;

      known_o = known_i;
      val_o   = val_i;
      pid_o   = pid_i;
      if (vld && trackable) begin
         unique case (op)
            OP_ADD:  val_o = val_i + imm;
            OP_SUB:  val_o = val_i - imm;
            default: begin
               val_o   = imm;
               known_o = 1'b1;
            end
         endcase
      end else if (untrk) begin
         known_o = 1'b0;
         val_o   = '0;
         pid_o   = id;
      end

      ea_vld = 1'b0;
      ea     = '0;
      if (is_load && (base == BASE_SP) && known_i) begin
         ea_vld = 1'b1;
         ea     = val_i + imm;
      end else if (is_load && (base == BASE_NONE)) begin
         ea_vld = 1'b1;
         ea     = imm;
      end
   end
endmodule

// File: rtl/sp_trk_ckpt.sv
module sp_trk_ckpt #(
   parameter int LANES = 3,
   parameter int DEPTH = 8,
   parameter int AW    = 32,
   parameter int IDW   = 8,
   parameter int TW    = $clog2(DEPTH)
) (
   input  logic               clk,
   input  logic               rst_n,
   input  logic [LANES-1:0]   wr_en,
   input  logic [LANES*TW-1:0]  wr_tag,
   input  logic [LANES-1:0]   wr_known,
   input  logic [LANES*AW-1:0]  wr_val,
   input  logic [LANES*IDW-1:0] wr_pid,
   input  logic [TW-1:0]      rd_tag,
   output logic               rd_known,
   output logic [AW-1:0]      rd_val,
   output logic [IDW-1:0]     rd_pid
);
   logic           ent_known [DEPTH];
   logic [AW-1:0]  ent_val   [DEPTH];
   logic [IDW-1:0] ent_pid   [DEPTH];

   for (genvar e = 0; e < DEPTH; e++) begin : g_ent
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n) begin
            ent_known[e] <= 1'b0;
            ent_val[e]   <= '0;
            ent_pid[e]   <= '0;
         end else begin
            for (int l = 0; l < LANES; l++) begin
               if (wr_en[l] && (wr_tag[l*TW +: TW] == TW'(e))) begin
                  ent_known[e] <= wr_known[l];
                  ent_val[e]   <= wr_val[l*AW +: AW];
                  ent_pid[e]   <= wr_pid[l*IDW +: IDW];
               end
            end
         end
      end
   end

   assign rd_known = ent_known[rd_tag];
   assign rd_val   = ent_val[rd_tag];
   assign rd_pid   = ent_pid[rd_tag];
endmodule

// File: rtl/stkptr_tracker.sv
module stkptr_tracker
   import sp_trk_pkg::*;
#(
   parameter int            LANES      = 3,
   parameter int            AW         = 32,
   parameter int            IDW        = 8,
   parameter int            CKPT_DEPTH = 8,
   parameter logic [AW-1:0] INIT_SP    = 'h0001_0000,
   localparam int           TW         = $clog2(CKPT_DEPTH)
) (
   input  logic                 clk,
   input  logic                 rst_n,
   input  logic [LANES-1:0]     uop_vld,
   input  logic [LANES*OPW-1:0] uop_op,
   input  logic [LANES-1:0]     uop_dst_sp,
   input  logic [LANES-1:0]     uop_src_sp,
   input  logic [LANES-1:0]     uop_src_imm,
   input  logic [LANES*BSW-1:0] uop_base,
   input  logic [LANES-1:0]     uop_index,
   input  logic [LANES*AW-1:0]  uop_imm,
   input  logic [LANES*IDW-1:0] uop_id,
   input  logic                 wb_vld,
   input  logic [IDW-1:0]       wb_id,
   input  logic [AW-1:0]        wb_val,
   input  logic                 flush_vld,
   input  logic [TW-1:0]        flush_tag,
   output logic [LANES-1:0]     ea_vld,
   output logic [LANES*AW-1:0]  ea_addr,
   output logic [LANES-1:0]     uop_untrk,
   output logic                 sp_known,
   output logic [AW-1:0]        sp_value
);
   if (LANES < 1 || CKPT_DEPTH < 2 || IDW < TW || AW < 2) begin : g_bad_cfg
      $error("stkptr_tracker: unsupported parameter set");
   end

   logic           known_q;
   logic [AW-1:0]  val_q;
   logic [IDW-1:0] pid_q;

   logic           rd_known;
   logic [AW-1:0]  rd_val;
   logic [IDW-1:0] rd_pid;

   logic           base_k, wb_hit;
   logic [AW-1:0]  base_v;
   logic [IDW-1:0] base_p;

   logic           ck_known [LANES+1];
   logic [AW-1:0]  ck_val   [LANES+1];
   logic [IDW-1:0] ck_pid   [LANES+1];

   logic [LANES-1:0]     lane_vld, lane_ea_vld, lane_untrk, lane_br, lane_ld_only;
   logic [LANES*AW-1:0]  lane_ea;
   logic [LANES*TW-1:0]  wr_tag;
   logic [LANES-1:0]     wr_known;
   logic [LANES*AW-1:0]  wr_val;
   logic [LANES*IDW-1:0] wr_pid;

   // Flush selects the restored slot, then a matching writeback rebases it.
   always_comb begin
      base_k = flush_vld ? rd_known : known_q;
      base_v = flush_vld ? rd_val   : val_q;
      base_p = flush_vld ? rd_pid   : pid_q;
      wb_hit = wb_vld && !base_k && (wb_id == base_p);
      ck_known[0] = base_k || wb_hit;
      ck_val[0]   = wb_hit ? (wb_val + base_v) : base_v;
      ck_pid[0]   = base_p;
   end

   for (genvar i = 0; i < LANES; i++) begin : g_lane
      assign lane_vld[i] = uop_vld[i] && !flush_vld;
      assign lane_ld_only[i] = !uop_vld[i] ||
                               ((uop_op[i*OPW +: OPW] == OP_LOAD) && !uop_dst_sp[i]);

      sp_trk_step #(.AW(AW), .IDW(IDW)) i_step (
         .vld       (lane_vld[i]),
         .op        (uop_op[i*OPW +: OPW]),
         .dst_sp    (uop_dst_sp[i]),
         .src_sp    (uop_src_sp[i]),
         .src_imm   (uop_src_imm[i]),
         .base      (uop_base[i*BSW +: BSW]),
         .index     (uop_index[i]),
         .imm       (uop_imm[i*AW +: AW]),
         .id        (uop_id[i*IDW +: IDW]),
         .known_i   (ck_known[i]),
         .val_i     (ck_val[i]),
         .pid_i     (ck_pid[i]),
         .known_o   (ck_known[i+1]),
         .val_o     (ck_val[i+1]),
         .pid_o     (ck_pid[i+1]),
         .ea_vld    (lane_ea_vld[i]),
         .ea        (lane_ea[i*AW +: AW]),
         .untrk     (lane_untrk[i]),
         .is_branch (lane_br[i])
      );

      assign wr_tag[i*TW +: TW]   = uop_id[i*IDW +: TW];
      assign wr_known[i]          = ck_known[i];
      assign wr_val[i*AW +: AW]   = ck_val[i];
      assign wr_pid[i*IDW +: IDW] = ck_pid[i];

      // R2: a stack load seen while unknown yields no early address
      p_no_ea_unknown_r2: assert property (@(posedge clk) disable iff (!rst_n)
         (lane_vld[i] && (uop_op[i*OPW +: OPW] == OP_LOAD) && !uop_index[i] &&
          (uop_base[i*BSW +: BSW] == BASE_SP) && !ck_known[i]) |=> !ea_vld[i]);
   end

   sp_trk_ckpt #(.LANES(LANES), .DEPTH(CKPT_DEPTH), .AW(AW), .IDW(IDW), .TW(TW)) i_ckpt (
      .clk      (clk),
      .rst_n    (rst_n),
      .wr_en    (lane_br),
      .wr_tag   (wr_tag),
      .wr_known (wr_known),
      .wr_val   (wr_val),
      .wr_pid   (wr_pid),
      .rd_tag   (flush_tag),
      .rd_known (rd_known),
      .rd_val   (rd_val),
      .rd_pid   (rd_pid)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         known_q   <= 1'b1;
         val_q     <= INIT_SP;
         pid_q     <= '0;
         ea_vld    <= '0;
         ea_addr   <= '0;
         uop_untrk <= '0;
      end else begin
         known_q   <= ck_known[LANES];
         val_q     <= ck_val[LANES];
         pid_q     <= ck_pid[LANES];
         ea_vld    <= lane_ea_vld;
         ea_addr   <= lane_ea;
         uop_untrk <= lane_untrk;
      end
   end

   assign sp_known = known_q;
   assign sp_value = val_q;

   // R6: an untrackable update in the last lane leaves the pointer unknown
   p_untrk_unknown_r6: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_vld && uop_vld[LANES-1] && lane_untrk[LANES-1]) |=> (!sp_known && sp_value == '0));

   // R8: matching writeback with no other traffic rebuilds the pointer
   p_resync_r8: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_vld && wb_vld && !known_q && (wb_id == pid_q) && (uop_vld == '0))
      |=> (sp_known && sp_value == $past(wb_val + val_q)));

   // R10: restoring a known checkpoint is immediate
   p_flush_known_r10: assert property (@(posedge clk) disable iff (!rst_n)
      (flush_vld && rd_known) |=> (sp_known && sp_value == $past(rd_val)));

   // R4: loads never write the tracked pointer
   p_load_keeps_sp_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_vld && !wb_vld && (&lane_ld_only)) |=> $stable(sp_value) && $stable(sp_known));

   // R13: a non-matching writeback is dropped
   p_stale_wb_r13: assert property (@(posedge clk) disable iff (!rst_n)
      (!flush_vld && wb_vld && (known_q || wb_id != pid_q) && (uop_vld == '0))
      |=> $stable(sp_value) && $stable(sp_known));
endmodule

// File: tb/test_stkptr_tracker.sv
module test_stkptr_tracker;
   localparam int L = 3;
   localparam int AW = 32;
   localparam int IDW = 8;

   logic clk = 1'b0;
   logic rst_n = 1'b0;
   logic [L-1:0]     uop_vld, uop_dst_sp, uop_src_sp, uop_src_imm, uop_index;
   logic [L*3-1:0]   uop_op;
   logic [L*2-1:0]   uop_base;
   logic [L*AW-1:0]  uop_imm;
   logic [L*IDW-1:0] uop_id;
   logic             wb_vld, flush_vld;
   logic [IDW-1:0]   wb_id;
   logic [AW-1:0]    wb_val;
   logic [2:0]       flush_tag;
   logic [L-1:0]     ea_vld, uop_untrk;
   logic [L*AW-1:0]  ea_addr;
   logic             sp_known;
   logic [AW-1:0]    sp_value;

   always #5 clk = ~clk;

   stkptr_tracker i_stkptr_tracker (
      .clk(clk), .rst_n(rst_n), .uop_vld(uop_vld), .uop_op(uop_op),
      .uop_dst_sp(uop_dst_sp), .uop_src_sp(uop_src_sp), .uop_src_imm(uop_src_imm),
      .uop_base(uop_base), .uop_index(uop_index), .uop_imm(uop_imm), .uop_id(uop_id),
      .wb_vld(wb_vld), .wb_id(wb_id), .wb_val(wb_val),
      .flush_vld(flush_vld), .flush_tag(flush_tag),
      .ea_vld(ea_vld), .ea_addr(ea_addr), .uop_untrk(uop_untrk),
      .sp_known(sp_known), .sp_value(sp_value)
   );

   typedef struct {
      logic [2:0]  ev;
      logic [2:0]  eu;
      logic [31:0] a [3];
      string       req;
   } exp_t;

   exp_t q[$];
   int n_chk = 0;
   int n_bad = 0;
   bit done = 0;

   localparam logic [2:0] ADD = 1, SUB = 2, MOVI = 3, LD = 4, BR = 5;
   localparam logic [1:0] B_NONE = 0, B_SP = 1, B_GPR = 2;

   task automatic clr();
      uop_vld = '0; uop_op = '0; uop_dst_sp = '0; uop_src_sp = '0;
      uop_src_imm = '0; uop_base = '0; uop_index = '0; uop_imm = '0; uop_id = '0;
      wb_vld = 0; wb_id = '0; wb_val = '0; flush_vld = 0; flush_tag = '0;
   endtask

   task automatic upd(int l, logic [2:0] op, logic d, logic s, logic im,
                      logic [31:0] imm, logic [7:0] id);
      uop_vld[l] = 1; uop_op[l*3 +: 3] = op; uop_dst_sp[l] = d; uop_src_sp[l] = s;
      uop_src_imm[l] = im; uop_imm[l*32 +: 32] = imm; uop_id[l*8 +: 8] = id;
   endtask

   task automatic ld(int l, logic [1:0] b, logic idx, logic [31:0] disp, logic [7:0] id);
      uop_vld[l] = 1; uop_op[l*3 +: 3] = LD; uop_base[l*2 +: 2] = b;
      uop_index[l] = idx; uop_imm[l*32 +: 32] = disp; uop_id[l*8 +: 8] = id;
   endtask

   task automatic wb(logic [7:0] id, logic [31:0] v);
      wb_vld = 1; wb_id = id; wb_val = v;
   endtask

   // driver: push the expected early outputs, then let one edge pass
   task automatic tick(logic [2:0] ev, logic [2:0] eu, logic [31:0] a0,
                       logic [31:0] a1, logic [31:0] a2, string req);
      exp_t e;
      e.ev = ev; e.eu = eu; e.a[0] = a0; e.a[1] = a1; e.a[2] = a2; e.req = req;
      q.push_back(e);
      @(negedge clk);
      clr();
   endtask

   task automatic state(logic k, logic [31:0] v, string req);
      n_chk++;
      if (sp_known !== k || sp_value !== v) begin
         n_bad++;
         $display("FAIL %s: state known=%0b value=%h, expected known=%0b value=%h",
                  req, sp_known, sp_value, k, v);
      end
   endtask

   // monitor: compare each cycle's outputs against the queued expectation
   always @(posedge clk) begin
      #1;
      if (q.size() > 0) begin
         exp_t e;
         e = q.pop_front();
         n_chk++;
         if (ea_vld !== e.ev || uop_untrk !== e.eu) begin
            n_bad++;
            $display("FAIL %s: ea_vld=%b untrk=%b, expected ea_vld=%b untrk=%b",
                     e.req, ea_vld, uop_untrk, e.ev, e.eu);
         end
         for (int l = 0; l < L; l++) begin
            if (e.ev[l] && ea_addr[l*32 +: 32] !== e.a[l]) begin
               n_chk++;
               n_bad++;
               $display("FAIL %s: lane %0d ea=%h, expected %h",
                        e.req, l, ea_addr[l*32 +: 32], e.a[l]);
            end
         end
      end
   end

   initial begin
      repeat (20000) @(posedge clk);
      if (!done) begin
         n_chk++;
         n_bad++;
         $display("FAIL watchdog: run did not finish, expected completion");
         $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
         $finish;
      end
   end

   initial begin
      clr();
      repeat (3) @(negedge clk);
      rst_n = 1;
      @(negedge clk);
      // R1 reset state
      state(1, 32'h0001_0000, "R1");
      n_chk++;
      if (ea_vld !== 0 || uop_untrk !== 0) begin
         n_bad++;
         $display("FAIL R1: ea_vld=%b untrk=%b, expected 0 0", ea_vld, uop_untrk);
      end
      // R3 SUB in known state
      upd(0, SUB, 1, 1, 1, 4, 1);
      tick(0, 0, 0, 0, 0, "R3");
      state(1, 32'h0000_FFFC, "R3");
      // R4 stack load
      ld(0, B_SP, 0, 8, 2);
      tick(3'b001, 0, 32'h0001_0004, 0, 0, "R4");
      state(1, 32'h0000_FFFC, "R4");
      // R5 other base, indexed stack load
      ld(0, B_GPR, 0, 8, 3);
      ld(1, B_SP, 1, 8, 4);
      tick(0, 0, 0, 0, 0, "R5");
      // R11 absolute load in known state
      ld(0, B_NONE, 0, 32'h1234, 5);
      tick(3'b001, 0, 32'h1234, 0, 0, "R11");
      // R12 chaining of lanes
      upd(0, ADD, 1, 1, 1, 32'h10, 6);
      ld(1, B_SP, 0, 4, 7);
      upd(2, SUB, 1, 1, 1, 8, 8);
      tick(3'b010, 0, 0, 32'h0001_0010, 0, "R12");
      state(1, 32'h0001_0004, "R12");
      // R6 R9 untrackable update; R2 stack load after it; R11 absolute still resolves
      upd(0, ADD, 1, 1, 0, 0, 8'h21);
      ld(1, B_SP, 0, 4, 8'h22);
      ld(2, B_NONE, 0, 32'h40, 8'h23);
      tick(3'b100, 3'b001, 0, 0, 32'h40, "R2 R6 R9 R11");
      state(0, 0, "R6");
      // R7 delta accumulation
      upd(0, SUB, 1, 1, 1, 32'h20, 8'h24);
      upd(1, ADD, 1, 1, 1, 4, 8'h25);
      tick(0, 0, 0, 0, 0, "R7");
      state(0, 32'hFFFF_FFE4, "R7");
      // R13 mismatched id
      wb(8'h22, 32'h5000);
      tick(0, 0, 0, 0, 0, "R13");
      state(0, 32'hFFFF_FFE4, "R13");
      // R8 resync
      wb(8'h21, 32'h8000);
      tick(0, 0, 0, 0, 0, "R8");
      state(1, 32'h0000_7FE4, "R8");
      ld(0, B_SP, 0, 0, 8'h26);
      tick(3'b001, 0, 32'h7FE4, 0, 0, "R4");
      // R13 writeback while known
      wb(8'h21, 32'h1);
      tick(0, 0, 0, 0, 0, "R13");
      state(1, 32'h0000_7FE4, "R13");
      // R7 second untrackable replaces id and delta
      upd(0, ADD, 1, 1, 0, 0, 8'h30);
      upd(1, ADD, 1, 1, 1, 8, 8'h31);
      tick(0, 3'b001, 0, 0, 0, "R7 R9");
      state(0, 8, "R7");
      upd(0, SUB, 1, 0, 0, 0, 8'h32);
      upd(1, ADD, 1, 1, 1, 4, 8'h33);
      tick(0, 3'b001, 0, 0, 0, "R7 R9");
      state(0, 4, "R7");
      wb(8'h30, 32'h100);
      tick(0, 0, 0, 0, 0, "R13");
      state(0, 4, "R13");
      // R8 resync with same-cycle update applied after
      wb(8'h32, 32'h200);
      upd(0, ADD, 1, 1, 1, 32'h10, 8'h34);
      tick(0, 0, 0, 0, 0, "R8");
      state(1, 32'h0000_0214, "R8");
      // R3 MOVI
      upd(0, MOVI, 1, 0, 1, 32'h9000, 8'h35);
      tick(0, 0, 0, 0, 0, "R3");
      state(1, 32'h0000_9000, "R3");
      // R10 known checkpoint, flush discards same-cycle update
      upd(0, BR, 0, 0, 0, 0, 8'h03);
      upd(1, SUB, 1, 1, 1, 32'h100, 8'h36);
      tick(0, 0, 0, 0, 0, "R10");
      state(1, 32'h0000_8F00, "R10");
      flush_vld = 1; flush_tag = 3;
      upd(0, SUB, 1, 1, 1, 4, 8'h37);
      ld(1, B_NONE, 0, 32'h55, 8'h38);
      tick(0, 0, 0, 0, 0, "R10");
      state(1, 32'h0000_9000, "R10");
      // R10 unknown checkpoint
      upd(0, ADD, 1, 1, 0, 0, 8'h40);
      upd(1, ADD, 1, 1, 1, 32'h10, 8'h41);
      upd(2, BR, 0, 0, 0, 0, 8'h05);
      tick(0, 3'b001, 0, 0, 0, "R10");
      state(0, 32'h10, "R10");
      upd(0, ADD, 1, 1, 1, 32'h20, 8'h42);
      upd(1, ADD, 1, 1, 0, 0, 8'h43);
      tick(0, 3'b010, 0, 0, 0, "R10");
      state(0, 0, "R10");
      flush_vld = 1; flush_tag = 5;
      tick(0, 0, 0, 0, 0, "R10");
      state(0, 32'h10, "R10");
      wb(8'h43, 32'h777);
      tick(0, 0, 0, 0, 0, "R13");
      state(0, 32'h10, "R13");
      wb(8'h40, 32'h1000);
      tick(0, 0, 0, 0, 0, "R10");
      state(1, 32'h0000_1010, "R10");
      // R7 MOVI while unknown
      upd(0, ADD, 1, 1, 0, 0, 8'h50);
      upd(1, MOVI, 1, 0, 1, 32'h3000, 8'h51);
      ld(2, B_SP, 0, 32'h10, 8'h52);
      tick(3'b100, 3'b001, 0, 0, 32'h3010, "R7 R12");
      state(1, 32'h0000_3000, "R7");
      // R3 modulo wrap both ways
      upd(0, MOVI, 1, 0, 1, 32'hFFFF_FFF0, 8'h53);
      upd(1, ADD, 1, 1, 1, 32'h20, 8'h54);
      tick(0, 0, 0, 0, 0, "R3");
      state(1, 32'h10, "R3");
      upd(0, SUB, 1, 1, 1, 32'h20, 8'h55);
      tick(0, 0, 0, 0, 0, "R3");
      state(1, 32'hFFFF_FFF0, "R3");
      repeat (2) @(negedge clk);
      n_chk++;
      if (q.size() != 0) begin
         n_bad++;
         $display("FAIL scoreboard: %0d items left, expected 0", q.size());
      end
      done = 1;
      $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
      $finish;
   end
endmodule